// File: doc/BRIEF.md
# Two-Thread Partitioned Micro-Op Queue

This block sits between the decode stage and the rename stage of a front end that runs two hardware threads at once. Each cycle the decode side may offer one micro-op per thread. The queue accepts at most one of them, chosen by a two-way round-robin arbiter. It keeps each thread's micro-ops in a ring of its own inside one shared storage array. Toward rename it presents one entry per cycle, taken from the head of one thread's ring. A second round-robin arbiter picks that thread among the threads whose rename side is ready.

In dual-thread mode the array is split into two equal halves. Neither thread can take more than half the entries, so a thread that backs up cannot starve the other. Single-thread mode gives the whole array to thread 0, and thread 1 is shut out. The mode can only change while the queue holds nothing. Each thread has a flush input that discards its own entries in one cycle and leaves the other thread untouched. Per-thread full and empty flags are exported.

Top module: `smt_uop_queue`

## Requirements
- R1: When both threads can be written in a cycle, the thread not granted at the previous write is granted, so writes alternate thread by thread.
- R2: In dual-thread mode each thread holds at most DEPTH/2 entries. `part_full[t]` is 1 exactly when thread t holds DEPTH/2 entries, and `in_ready[t]` is then 0.
- R3: A thread that cannot write (its part is full) or cannot drain (its `out_ready` bit is 0) never stops the other thread from writing or draining in that cycle.
- R4: In single-thread mode (`single_mode` = 1) thread 0 may hold DEPTH entries. Thread 1 then has `in_ready[1]` = 0 and `part_full[1]` = 1.
- R5: The entries of one thread leave on `out_data` in the order they were accepted.
- R6: When only one thread can be written, that thread is granted, even if it was also granted at the previous write.
- R7: `flush[t]` = 1 empties thread t's part at the next edge. The other thread's entries stay in place and in order. A flushed thread neither writes nor drains in that cycle.
- R8: A pulse on `mode_wr` loads `mode_req` into `single_mode` only when both parts are empty and no write takes place in that cycle. Otherwise the pulse is ignored.
- R9: Each entry stores the number of the thread that wrote it, and that number is presented on `out_tid` (0 = thread 0, 1 = thread 1).
- R10: An entry is presented (`out_valid` = 1) whenever some thread t has an entry and `out_ready[t]` = 1. A presented entry is consumed in that cycle. When both threads qualify, the thread not served at the previous drain is chosen.
- R11: After reset both parts are empty, the mode is dual-thread, and the first contended write and the first contended drain both go to thread 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 2 | Per-thread micro-op offered |
| in_data_t0 | input | PW | Payload offered by thread 0 |
| in_data_t1 | input | PW | Payload offered by thread 1 |
| in_ready | output | 2 | Per-thread write grant; at most one bit is set |
| flush | input | 2 | Per-thread discard of all held entries |
| mode_wr | input | 1 | Request to load a new mode |
| mode_req | input | 1 | Mode to load: 1 = single-thread, 0 = dual-thread |
| single_mode | output | 1 | Current mode |
| out_ready | input | 2 | Per-thread rename-side ready |
| out_valid | output | 1 | An entry is presented and consumed this cycle |
| out_tid | output | 1 | Thread of the presented entry |
| out_data | output | PW | Payload of the presented entry |
| part_full | output | 2 | Per-thread part at capacity |
| part_empty | output | 2 | Per-thread part holds nothing |

## Verification
Writes, drains, flushes and mode requests can all land in the same cycle. The cases that matter most are a flush of one thread while the other thread writes and drains, and a mode request in the cycle where the last entry leaves or a new one arrives. The stimulus raises the flush and mode inputs at random while traffic flows in both directions, and it holds one thread's rename side low so that its part fills up while the other thread keeps moving. A behavioural model built on two queues gives the expected grants, flags and head entries for every cycle, and these are compared with the ports. In those collision cycles the model decides whether the mode request takes effect, and which thread's entries survive.

// File: rtl/smtq_pkg.sv
package smtq_pkg;
   typedef enum logic {
      MODE_DUAL   = 1'b0,
      MODE_SINGLE = 1'b1
   } smtq_mode_e;

   localparam int unsigned SMTQ_THREADS = 2;
endpackage

// File: rtl/smtq_rr2.sv
module smtq_rr2 (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] req,
   output logic [1:0] gnt
);
   logic last_q;  // thread granted most recently

   always_comb begin
      if (req == 2'b11) gnt = last_q ? 2'b01 : 2'b10;
      else              gnt = req;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   last_q <= 1'b1;
      else if (|req) last_q <= gnt[1];
   end
endmodule

// File: rtl/smtq_part.sv
module smtq_part #(
   parameter int unsigned AW = 4,
   parameter int unsigned CW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic          pop,
   input  logic [CW-1:0] cap,
   input  logic [AW-1:0] base,
   output logic [AW-1:0] wr_addr,
   output logic [AW-1:0] rd_addr,
   output logic          full,
   output logic          empty
);
   logic [AW-1:0] head_q, tail_q;
   logic [CW-1:0] cnt_q;

   function automatic logic [AW-1:0] step(input logic [AW-1:0] p, input logic [CW-1:0] lim);
      logic [CW-1:0] nxt;
      nxt = CW'(p) + CW'(1);
      return (nxt >= lim) ? '0 : AW'(nxt);
   endfunction

   assign full    = (cnt_q >= cap);
   assign empty   = (cnt_q == '0);
   assign wr_addr = base + tail_q;
   assign rd_addr = base + head_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
         cnt_q  <= '0;
      end else if (clr) begin
         head_q <= '0;
         tail_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (push) tail_q <= step(tail_q, cap);
         if (pop)  head_q <= step(head_q, cap);
         case ({push, pop})
            2'b10:   cnt_q <= cnt_q + CW'(1);
            2'b01:   cnt_q <= cnt_q - CW'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end
endmodule

// File: rtl/smt_uop_queue.sv
module smt_uop_queue #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned PW    = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    in_valid,
   input  logic [PW-1:0] in_data_t0,
   input  logic [PW-1:0] in_data_t1,
   output logic [1:0]    in_ready,
   input  logic [1:0]    flush,
   input  logic          mode_wr,
   input  logic          mode_req,
   output logic          single_mode,
   input  logic [1:0]    out_ready,
   output logic          out_valid,
   output logic          out_tid,
   output logic [PW-1:0] out_data,
   output logic [1:0]    part_full,
   output logic [1:0]    part_empty
);
   import smtq_pkg::*;

   localparam int unsigned HALF = DEPTH / 2;
   localparam int unsigned AW   = $clog2(DEPTH);
   localparam int unsigned CW   = $clog2(DEPTH + 1);
   localparam int unsigned EW   = PW + 1;

   initial begin
      assert (DEPTH >= 4 && DEPTH % 2 == 0) else $error("DEPTH must be even and at least 4");
      assert (PW >= 1) else $error("PW must be at least 1");
   end

   smtq_mode_e    mode_q;
   logic [EW-1:0] mem [DEPTH];
   logic [1:0]    wr_cand, rd_cand, wgnt, rgnt;
   logic [AW-1:0] wr_addr [SMTQ_THREADS];
   logic [AW-1:0] rd_addr [SMTQ_THREADS];
   logic          mode_apply;

   assign single_mode = (mode_q == MODE_SINGLE);
   assign mode_apply  = mode_wr && (&part_empty) && !(|wgnt);

   for (genvar t = 0; t < SMTQ_THREADS; t++) begin : g_part
      logic [CW-1:0] cap;
      if (t == 0) begin : g_cap0
         assign cap = single_mode ? CW'(DEPTH) : CW'(HALF);
      end else begin : g_cap1
         assign cap = single_mode ? '0 : CW'(HALF);
      end

      assign wr_cand[t] = in_valid[t] && !flush[t] && !part_full[t];
      assign rd_cand[t] = !part_empty[t] && out_ready[t] && !flush[t];

      smtq_part #(.AW(AW), .CW(CW)) u_part (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr     (flush[t] || mode_apply),
         .push    (wgnt[t]),
         .pop     (rgnt[t]),
         .cap     (cap),
         .base    (AW'(t * HALF)),
         .wr_addr (wr_addr[t]),
         .rd_addr (rd_addr[t]),
         .full    (part_full[t]),
         .empty   (part_empty[t])
      );
   end

   smtq_rr2 u_wr_arb (.clk(clk), .rst_n(rst_n), .req(wr_cand), .gnt(wgnt));
   smtq_rr2 u_rd_arb (.clk(clk), .rst_n(rst_n), .req(rd_cand), .gnt(rgnt));

   assign in_ready = wgnt;

   always_ff @(posedge clk) begin
      if (wgnt[0])      mem[wr_addr[0]] <= {1'b0, in_data_t0};
      else if (wgnt[1]) mem[wr_addr[1]] <= {1'b1, in_data_t1};
   end

   logic [EW-1:0] head_ent;
   assign head_ent  = rgnt[1] ? mem[rd_addr[1]] : mem[rd_addr[0]];
   assign out_valid = |rgnt;
   assign out_tid   = head_ent[PW];
   assign out_data  = head_ent[PW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          mode_q <= MODE_DUAL;
      else if (mode_apply) mode_q <= smtq_mode_e'(mode_req);
   end
endmodule

// File: rtl/smtq_checker.sv
module smtq_checker (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] in_valid,
   input logic [1:0] in_ready,
   input logic [1:0] flush,
   input logic       single_mode,
   input logic [1:0] out_ready,
   input logic       out_valid,
   input logic       out_tid,
   input logic [1:0] part_full,
   input logic [1:0] part_empty
);
   AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(in_ready) && ((in_ready & ~in_valid) == 2'b00)); // R1

   AST_WR_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(in_ready) == 2'b01 && in_valid == 2'b11 && part_full == 2'b00 && flush == 2'b00)
      |-> in_ready == 2'b10); // R1

   AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      part_full[0] |-> !in_ready[0]); // R2

   AST_OTHER_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
      (part_full[0] && in_valid[1] && !part_full[1] && !flush[1]) |-> in_ready[1]); // R3

   AST_SINGLE_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
      single_mode |-> (!in_ready[1] && part_full[1])); // R4

   AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      flush[1] |=> part_empty[1]); // R7

   AST_MODE_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (single_mode != $past(single_mode)) |-> $past(&part_empty)); // R8

   AST_OUT_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_ready[out_tid] && !part_empty[out_tid] && !flush[out_tid])); // R10

   AST_RD_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(out_valid) && $past(out_tid) == 1'b0 && out_ready == 2'b11
       && part_empty == 2'b00 && flush == 2'b00) |-> (out_valid && out_tid)); // R10
endmodule

bind smt_uop_queue smtq_checker u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .in_ready    (in_ready),
   .flush       (flush),
   .single_mode (single_mode),
   .out_ready   (out_ready),
   .out_valid   (out_valid),
   .out_tid     (out_tid),
   .part_full   (part_full),
   .part_empty  (part_empty)
);

// File: tb/smt_uop_queue_tb_top.sv
`timescale 1ns/1ps
module smt_uop_queue_tb_top;
   localparam int DEPTH = 16;
   localparam int PW    = 8;
   localparam int HALF  = DEPTH / 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    in_valid = '0, flush = '0, out_ready = '0;
   logic [PW-1:0] in_data_t0 = '0, in_data_t1 = '0;
   logic          mode_wr = 1'b0, mode_req = 1'b0;
   logic [1:0]    in_ready, part_full, part_empty;
   logic          single_mode, out_valid, out_tid;
   logic [PW-1:0] out_data;

   always #2.5 clk = ~clk;

   smt_uop_queue #(.DEPTH(DEPTH), .PW(PW)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data_t0(in_data_t0),
      .in_data_t1(in_data_t1), .in_ready(in_ready), .flush(flush), .mode_wr(mode_wr),
      .mode_req(mode_req), .single_mode(single_mode), .out_ready(out_ready),
      .out_valid(out_valid), .out_tid(out_tid), .out_data(out_data),
      .part_full(part_full), .part_empty(part_empty));

   int checks = 0, errors = 0;
   bit done = 0;

   // reference state
   logic [PW-1:0] q0[$], q1[$];
   bit m_single = 0, last_w = 1, last_r = 1;
   bit flushed_prev0 = 0, flushed_prev1 = 0;

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int size_of(int t);
      return (t == 0) ? q0.size() : q1.size();
   endfunction

   function automatic int cap_of(int t);
      if (m_single) return (t == 0) ? DEPTH : 0;
      return HALF;
   endfunction

   task automatic run_phase(int n, int p_in0, int p_in1, int p_rd0, int p_rd1,
                            int p_fl, int p_mode, bit req);
      for (int i = 0; i < n; i++) begin
         bit [1:0] wc, rc, eg, er;
         @(negedge clk);
         in_valid[0] = ($urandom_range(99) < p_in0);
         in_valid[1] = ($urandom_range(99) < p_in1);
         in_data_t0  = PW'($urandom);
         in_data_t1  = PW'($urandom);
         out_ready[0] = ($urandom_range(99) < p_rd0);
         out_ready[1] = ($urandom_range(99) < p_rd1);
         flush[0] = ($urandom_range(999) < p_fl);
         flush[1] = ($urandom_range(999) < p_fl);
         mode_wr  = ($urandom_range(99) < p_mode);
         mode_req = req;
         #1;
         for (int t = 0; t < 2; t++) begin
            wc[t] = in_valid[t] && !flush[t] && (size_of(t) < cap_of(t));
            rc[t] = (size_of(t) > 0) && out_ready[t] && !flush[t];
         end
         eg = (wc == 2'b11) ? (last_w ? 2'b01 : 2'b10) : wc;
         er = (rc == 2'b11) ? (last_r ? 2'b01 : 2'b10) : rc;
         // write grant: alternation, single-candidate, stall isolation
         if (wc == 2'b11)                                   chk(in_ready == eg, "R1", in_ready, eg);
         else if (part_full != 2'b00 && in_valid != 2'b00) chk(in_ready == eg, "R3", in_ready, eg);
         else                                               chk(in_ready == eg, "R6", in_ready, eg);
         for (int t = 0; t < 2; t++) begin
            bit ef = size_of(t) >= cap_of(t);
            chk(part_full[t] == ef, m_single ? "R4" : "R2", part_full[t], ef);
            if ((t == 0 && flushed_prev0) || (t == 1 && flushed_prev1))
               chk(part_empty[t] == (size_of(t) == 0), "R7", part_empty[t], size_of(t) == 0);
            else
               chk(part_empty[t] == (size_of(t) == 0), "R2", part_empty[t], size_of(t) == 0);
         end
         chk(single_mode == m_single, "R8", single_mode, m_single);
         chk(out_valid == (er != 2'b00), (rc != 2'b11 && rc != 2'b00) ? "R3" : "R10",
             out_valid, er != 2'b00);
         if (er != 2'b00) begin
            chk(out_tid == er[1], "R10", out_tid, er[1]);
            if (er[1]) chk(out_data == q1[0], "R5", out_data, q1[0]);
            else       chk(out_data == q0[0], "R5", out_data, q0[0]);
            chk(out_tid == er[1], "R9", out_tid, er[1]);
         end
         @(posedge clk);
         // model update
         if (mode_wr && q0.size() == 0 && q1.size() == 0 && eg == 2'b00) begin
            m_single = mode_req;
         end
         if (er[0]) void'(q0.pop_front());
         if (er[1]) void'(q1.pop_front());
         if (eg[0]) q0.push_back(in_data_t0);
         if (eg[1]) q1.push_back(in_data_t1);
         if (flush[0]) q0.delete();
         if (flush[1]) q1.delete();
         if (wc != 2'b00) last_w = eg[1];
         if (rc != 2'b00) last_r = er[1];
         flushed_prev0 = flush[0];
         flushed_prev1 = flush[1];
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R11: reset state
      chk(part_empty == 2'b11, "R11", part_empty, 3);
      chk(single_mode == 1'b0, "R11", single_mode, 0);
      chk(out_valid == 1'b0, "R11", out_valid, 0);
      // R11/R1: first contended write goes to thread 0 (checked inside the phase)
      run_phase(1, 100, 100, 0, 0, 0, 0, 0);
      // R2: fill both parts with rename stalled
      run_phase(30, 100, 100, 0, 0, 0, 0, 0);
      // R3: thread 1 drain blocked while thread 0 flows
      run_phase(200, 90, 90, 80, 0, 0, 0, 0);
      // R10/R5: contended drains
      run_phase(300, 60, 60, 90, 90, 0, 0, 0);
      // R7: flushes amid traffic
      run_phase(400, 70, 70, 60, 60, 40, 0, 0);
      // R8: mode requests while busy are ignored
      run_phase(200, 80, 80, 30, 30, 0, 30, 1);
      // drain, then enter single-thread mode
      run_phase(40, 0, 0, 100, 100, 0, 0, 0);
      run_phase(2, 0, 0, 100, 100, 0, 100, 1);
      // R4: thread 0 fills the whole array, thread 1 shut out
      run_phase(30, 100, 100, 0, 0, 0, 0, 1);
      run_phase(300, 70, 70, 50, 50, 20, 10, 1);
      // back to dual-thread mode
      run_phase(40, 0, 0, 100, 100, 0, 0, 0);
      run_phase(2, 0, 0, 100, 100, 0, 100, 0);
      run_phase(400, 70, 70, 70, 70, 20, 5, 0);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule